// File: doc/BRIEF.md
# In-Order Load Retirement Queue

This block sits between the memory stage of a pipelined CPU and a memory that answers loads after a variable delay and in any order. Each accepted load takes a queue entry. The entry stores the load's byte offset and its load kind. The block sends a word-aligned request to memory, tagged with a flush epoch and the entry index.

Responses come back carrying that tag, and their data is written into the matching entry. Results go to write-back only from the oldest entry, so results leave in issue order even when younger loads are answered first. The selected byte, halfword or word is extended to 32 bits, with sign or zero extension, at the moment of retirement.

A flush input discards every load that has not yet retired. Responses that arrive later for a discarded load are recognised by their old epoch and dropped.

Top module: `ld_retire_q`

## Requirements
- R1: After reset the queue is empty: `ret_valid` is 0, `iss_full` is 0 and `mreq_valid` is 0 while no load is offered.
- R2: An accepted issue raises `mreq_valid` in the same cycle, with `mreq_waddr` = `iss_addr[31:2]`. `mreq_tag` is {epoch, entry index}, with the index in the low log2(DEPTH) bits. Entries are taken in increasing index order modulo DEPTH, starting at 0 after reset.
- R3: With DEPTH loads unretired, `iss_full` is 1 and `mreq_valid` stays 0 even when `iss_valid` is 1. The refused load takes no entry.
- R4: A response for a younger entry is held, and `ret_valid` stays 0 until the oldest entry has its response.
- R5: `ret_valid` rises in the cycle after the oldest entry's response is accepted. Each cycle with `ret_valid` high retires exactly one entry, so held results leave on consecutive cycles in issue order.
- R6: `iss_kind` selects the extension: 000 signed byte, 001 signed halfword, 010 word, 100 unsigned byte, 101 unsigned halfword. The field is extracted from the returned word starting at bit 8*`iss_addr[1:0]`.
- R7: A flush cycle holds `ret_valid` at 0, empties the queue, resets the next entry index to 0 and advances the epoch by one (modulo 2^EPW). Responses carrying an older epoch are ignored.
- R8: A response whose entry is not in flight, or whose entry already holds a response, is ignored.
- R9: An issue offered in a flush cycle is refused: `mreq_valid` is 0 and no entry is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all unretired loads |
| iss_valid | input | 1 | Load offered by the pipeline |
| iss_addr | input | 32 | Byte address of the load |
| iss_kind | input | 3 | Load kind (width and signedness) |
| iss_full | output | 1 | No free entry; issue stalls |
| mreq_valid | output | 1 | Memory read request |
| mreq_waddr | output | 30 | Word address of the request |
| mreq_tag | output | EPW+log2(DEPTH) | Epoch and entry index |
| mrsp_valid | input | 1 | Memory response valid |
| mrsp_tag | input | EPW+log2(DEPTH) | Tag returned with the response |
| mrsp_data | input | 32 | Returned word |
| ret_valid | output | 1 | Result retires this cycle |
| ret_data | output | 32 | Extended load result |

## Verification
The hardest state to reach from the ports is a stale response landing on an entry index that has just been reused by a newer load after a flush. Only the epoch bits keep that response out.

The bench gets there in four steps. It flushes while two loads are in flight. It issues a new load, which takes index 0 again. It then returns a response with the pre-flush epoch for index 0 and checks that nothing retires. Last, it answers the new tag and checks the result.

The entries are filled completely, and younger entries are answered before the oldest. This confirms that responses are held back and then released on consecutive cycles.

// File: rtl/lrq_pkg.sv
package lrq_pkg;
  localparam int XLEN = 32;

  typedef enum logic [2:0] {
    LK_SBYTE = 3'b000,
    LK_SHALF = 3'b001,
    LK_WORD  = 3'b010,
    LK_UBYTE = 3'b100,
    LK_UHALF = 3'b101
  } ld_kind_e;
endpackage

// File: rtl/lrq_ptrs.sv
module lrq_ptrs #(
  parameter int DEPTH = 4,
  parameter int EPW   = 2,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            push,
  input  logic            pop,
  output logic [IDXW-1:0] head,
  output logic [IDXW-1:0] tail,
  output logic [EPW-1:0]  epoch,
  output logic            full,
  output logic            empty
);
  logic [IDXW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [EPW-1:0]  ep_q, ep_d;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    ep_d   = ep_q;
    if (flush) begin
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
      ep_d   = ep_q + EPW'(1);
    end else begin
      if (push) tail_d = tail_q + IDXW'(1);
      if (pop)  head_d = head_q + IDXW'(1);
      cnt_d = cnt_q + CNTW'(push) - CNTW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      ep_q   <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
      ep_q   <= ep_d;
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign epoch = ep_q;
  assign full  = (cnt_q == CNTW'(DEPTH));
  assign empty = (cnt_q == '0);

  // R3
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(DEPTH));

  // R5
  head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush) |=> (head_q == $past(head_q) + IDXW'(1)));

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (empty && head_q == '0 && tail_q == '0));
endmodule

// File: rtl/lrq_store.sv
module lrq_store
  import lrq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            alloc,
  input  logic [IDXW-1:0] alloc_idx,
  input  logic [1:0]      alloc_off,
  input  ld_kind_e        alloc_kind,
  input  logic            wr_valid,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            free,
  input  logic [IDXW-1:0] rd_idx,
  output logic            rd_busy,
  output logic            rd_done,
  output logic [1:0]      rd_off,
  output ld_kind_e        rd_kind,
  output logic [XLEN-1:0] rd_data
);
  logic            busy_q [DEPTH];
  logic            done_q [DEPTH];
  logic [1:0]      off_q  [DEPTH];
  ld_kind_e        kind_q [DEPTH];
  logic [XLEN-1:0] data_q [DEPTH];
  logic            wr_acc;

  assign wr_acc = wr_valid && busy_q[wr_idx] && !done_q[wr_idx];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    logic set_alloc, set_wr, clr;
    logic busy_d, done_d;

    always_comb begin
      set_alloc = alloc && (alloc_idx == IDXW'(gi));
      set_wr    = wr_acc && (wr_idx == IDXW'(gi));
      clr       = flush || (free && rd_idx == IDXW'(gi));
      busy_d    = busy_q[gi];
      done_d    = done_q[gi];
      if (clr) begin
        busy_d = 1'b0;
        done_d = 1'b0;
      end else if (set_alloc) begin
        busy_d = 1'b1;
        done_d = 1'b0;
      end else if (set_wr) begin
        done_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q[gi] <= 1'b0;
        done_q[gi] <= 1'b0;
      end else begin
        busy_q[gi] <= busy_d;
        done_q[gi] <= done_d;
      end
    end

    always_ff @(posedge clk) begin
      if (set_alloc) begin
        off_q[gi]  <= alloc_off;
        kind_q[gi] <= alloc_kind;
      end
    end

    always_ff @(posedge clk) begin
      if (set_wr) data_q[gi] <= wr_data;
    end

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q[gi] && !clr) |=> $stable(data_q[gi]));

    // R4
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q[gi] |-> busy_q[gi]);
  end

  assign rd_busy = busy_q[rd_idx];
  assign rd_done = done_q[rd_idx];
  assign rd_off  = off_q[rd_idx];
  assign rd_kind = kind_q[rd_idx];
  assign rd_data = data_q[rd_idx];
endmodule

// File: rtl/lrq_extend.sv
module lrq_extend
  import lrq_pkg::*;
(
  input  logic [XLEN-1:0] raw,
  input  logic [1:0]      off,
  input  ld_kind_e        kind,
  output logic [XLEN-1:0] val
);
  logic [XLEN-1:0] lane;

  always_comb begin
    lane = raw >> {off, 3'b000};
    unique case (kind)
      LK_SBYTE: val = {{(XLEN-8){lane[7]}}, lane[7:0]};
      LK_UBYTE: val = {{(XLEN-8){1'b0}}, lane[7:0]};
      LK_SHALF: val = {{(XLEN-16){lane[15]}}, lane[15:0]};
      LK_UHALF: val = {{(XLEN-16){1'b0}}, lane[15:0]};
      default:  val = raw;
    endcase
  end
endmodule

// File: rtl/ld_retire_q.sv
module ld_retire_q
  import lrq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int EPW   = 2,
  localparam int IDXW = $clog2(DEPTH),
  localparam int TAGW = EPW + IDXW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            iss_valid,
  input  logic [31:0]     iss_addr,
  input  logic [2:0]      iss_kind,
  output logic            iss_full,
  output logic            mreq_valid,
  output logic [29:0]     mreq_waddr,
  output logic [TAGW-1:0] mreq_tag,
  input  logic            mrsp_valid,
  input  logic [TAGW-1:0] mrsp_tag,
  input  logic [31:0]     mrsp_data,
  output logic            ret_valid,
  output logic [31:0]     ret_data
);
  logic            push, pop, full, empty;
  logic [IDXW-1:0] head, tail;
  logic [EPW-1:0]  epoch;
  logic            rsp_live;
  logic            h_busy, h_done;
  logic [1:0]      h_off;
  ld_kind_e        h_kind;
  logic [31:0]     h_data;

  assign push     = iss_valid && !full && !flush;
  assign rsp_live = mrsp_valid && !flush && (mrsp_tag[TAGW-1:IDXW] == epoch);
  assign pop      = h_busy && h_done && !flush;

  lrq_ptrs #(.DEPTH(DEPTH), .EPW(EPW)) u_ptrs (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (push),
    .pop   (pop),
    .head  (head),
    .tail  (tail),
    .epoch (epoch),
    .full  (full),
    .empty (empty)
  );

  lrq_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .alloc      (push),
    .alloc_idx  (tail),
    .alloc_off  (iss_addr[1:0]),
    .alloc_kind (ld_kind_e'(iss_kind)),
    .wr_valid   (rsp_live),
    .wr_idx     (mrsp_tag[IDXW-1:0]),
    .wr_data    (mrsp_data),
    .free       (pop),
    .rd_idx     (head),
    .rd_busy    (h_busy),
    .rd_done    (h_done),
    .rd_off     (h_off),
    .rd_kind    (h_kind),
    .rd_data    (h_data)
  );

  lrq_extend u_ext (
    .raw  (h_data),
    .off  (h_off),
    .kind (h_kind),
    .val  (ret_data)
  );

  assign iss_full   = full;
  assign mreq_valid = push;
  assign mreq_waddr = iss_addr[31:2];
  assign mreq_tag   = {epoch, tail};
  assign ret_valid  = pop;

  // R3
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_full |-> !mreq_valid);

  // R9
  flush_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!mreq_valid && !ret_valid));

  // R7
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !ret_valid);

  // R4
  empty_no_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !ret_valid);
endmodule

// File: tb/test_ld_retire_q.sv
`timescale 1ns/1ps
module test_ld_retire_q;
  localparam int TAGW = 4;
  localparam int NV   = 12;

  // {kind, offset, returned word, expected result}
  localparam logic [68:0] VECS [NV] = '{
    {3'b000, 2'd0, 32'h8A7FF001, 32'h00000001},
    {3'b000, 2'd1, 32'h8A7FF001, 32'hFFFFFFF0},
    {3'b100, 2'd1, 32'h8A7FF001, 32'h000000F0},
    {3'b000, 2'd3, 32'h8A7FF001, 32'hFFFFFF8A},
    {3'b100, 2'd2, 32'h8A7FF001, 32'h0000007F},
    {3'b001, 2'd0, 32'h8A7FF001, 32'hFFFFF001},
    {3'b101, 2'd0, 32'h8A7FF001, 32'h0000F001},
    {3'b001, 2'd2, 32'h8A7FF001, 32'hFFFF8A7F},
    {3'b101, 2'd2, 32'h8A7FF001, 32'h00008A7F},
    {3'b010, 2'd0, 32'h8A7FF001, 32'h8A7FF001},
    {3'b000, 2'd2, 32'h8A7FF001, 32'h0000007F},
    {3'b001, 2'd0, 32'h12347FFE, 32'h00007FFE}
  };

  logic            clk = 1'b0;
  logic            rst_n, flush, iss_valid, mrsp_valid;
  logic [31:0]     iss_addr, mrsp_data;
  logic [2:0]      iss_kind;
  logic            iss_full, mreq_valid, ret_valid;
  logic [29:0]     mreq_waddr;
  logic [TAGW-1:0] mreq_tag, mrsp_tag;
  logic [31:0]     ret_data;

  int nchk = 0;
  int nerr = 0;
  int tail_m = 0;
  int ep_m = 0;

  always #2 clk = ~clk;

  ld_retire_q i_ld_retire_q (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .iss_valid  (iss_valid),
    .iss_addr   (iss_addr),
    .iss_kind   (iss_kind),
    .iss_full   (iss_full),
    .mreq_valid (mreq_valid),
    .mreq_waddr (mreq_waddr),
    .mreq_tag   (mreq_tag),
    .mrsp_valid (mrsp_valid),
    .mrsp_tag   (mrsp_tag),
    .mrsp_data  (mrsp_data),
    .ret_valid  (ret_valid),
    .ret_data   (ret_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic issue(input logic [2:0] kind, input logic [31:0] addr,
                       output logic [TAGW-1:0] tag);
    iss_valid = 1'b1;
    iss_addr  = addr;
    iss_kind  = kind;
    #0.5;
    chk("R2 mreq_valid", 32'(mreq_valid), 32'd1);
    chk("R2 mreq_waddr", 32'(mreq_waddr), 32'(addr[31:2]));
    chk("R2 mreq_tag", 32'(mreq_tag), 32'((ep_m << 2) | tail_m));
    tag = mreq_tag;
    tick();
    iss_valid = 1'b0;
    tail_m = (tail_m + 1) % 4;
  endtask

  task automatic respond(input logic [TAGW-1:0] tag, input logic [31:0] data);
    mrsp_valid = 1'b1;
    mrsp_tag   = tag;
    mrsp_data  = data;
    tick();
    mrsp_valid = 1'b0;
  endtask

  initial begin
    #400000;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    logic [TAGW-1:0] t [4];
    logic [TAGW-1:0] ta, tb, tn;
    logic [1:0]      old_ep;

    rst_n = 1'b0; flush = 1'b0; iss_valid = 1'b0; mrsp_valid = 1'b0;
    iss_addr = '0; iss_kind = '0; mrsp_tag = '0; mrsp_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 ret_valid", 32'(ret_valid), 32'd0);
    chk("R1 iss_full", 32'(iss_full), 32'd0);
    chk("R1 mreq_valid", 32'(mreq_valid), 32'd0);

    // R6 extension table
    for (int i = 0; i < NV; i++) begin
      logic [TAGW-1:0] tg;
      issue(VECS[i][68:66], 32'h0000_1000 + 32'(i * 4) + 32'(VECS[i][65:64]), tg);
      respond(tg, VECS[i][63:32]);
      chk("R5 ret_valid after response", 32'(ret_valid), 32'd1);
      chk("R6 ret_data", ret_data, VECS[i][31:0]);
      tick();
      chk("R5 single retire", 32'(ret_valid), 32'd0);
    end

    // R3 fill the queue
    for (int i = 0; i < 4; i++) begin
      logic [TAGW-1:0] tg;
      issue(3'b010, 32'h0000_2000 + 32'(i * 4), tg);
      t[i] = tg;
    end
    chk("R3 iss_full", 32'(iss_full), 32'd1);
    iss_valid = 1'b1; iss_addr = 32'h0000_3000; iss_kind = 3'b010;
    #0.5;
    chk("R3 refused mreq_valid", 32'(mreq_valid), 32'd0);
    tick();
    iss_valid = 1'b0;
    chk("R3 still full", 32'(iss_full), 32'd1);

    // R4 younger responses first
    respond(t[3], 32'hD000_0003);
    chk("R4 hold t3", 32'(ret_valid), 32'd0);
    respond(t[1], 32'hD000_0001);
    chk("R4 hold t1", 32'(ret_valid), 32'd0);
    respond(t[2], 32'hD000_0002);
    chk("R4 hold t2", 32'(ret_valid), 32'd0);
    respond(t[0], 32'hD000_0000);
    for (int i = 0; i < 4; i++) begin
      chk("R5 back-to-back valid", 32'(ret_valid), 32'd1);
      chk("R5 in-order data", ret_data, 32'hD000_0000 + 32'(i));
      tick();
    end
    chk("R5 drained", 32'(ret_valid), 32'd0);
    chk("R3 free again", 32'(iss_full), 32'd0);

    // R8 response to an idle entry, then a duplicate response
    respond(4'((ep_m << 2) | tail_m), 32'h0000_0BAD);
    chk("R8 idle entry response", 32'(ret_valid), 32'd0);
    issue(3'b010, 32'h0000_4000, ta);
    chk("R8 new entry not done", 32'(ret_valid), 32'd0);
    issue(3'b010, 32'h0000_4004, tb);
    respond(tb, 32'h1111_1111);
    respond(tb, 32'h2222_2222);
    respond(ta, 32'hAAAA_AAAA);
    chk("R8 first retire", ret_data, 32'hAAAA_AAAA);
    tick();
    chk("R8 duplicate ignored", ret_data, 32'h1111_1111);
    tick();
    chk("R8 drained", 32'(ret_valid), 32'd0);

    // R7 flush with loads in flight
    issue(3'b010, 32'h0000_5000, ta);
    issue(3'b010, 32'h0000_5004, tb);
    respond(ta, 32'h7777_0000);
    flush = 1'b1;
    #0.5;
    chk("R7 no retire during flush", 32'(ret_valid), 32'd0);
    tick();
    flush = 1'b0;
    old_ep = 2'(ep_m);
    ep_m = (ep_m + 1) % 4;
    tail_m = 0;
    chk("R7 empty after flush", 32'(ret_valid), 32'd0);
    chk("R7 not full", 32'(iss_full), 32'd0);
    respond(tb, 32'h7777_0001);
    chk("R7 stale response", 32'(ret_valid), 32'd0);
    issue(3'b010, 32'h0000_6000, tn);
    respond({old_ep, 2'd0}, 32'h7777_0002);
    chk("R7 stale tag on reused index", 32'(ret_valid), 32'd0);
    respond(tn, 32'h5555_AAAA);
    chk("R7 fresh retire", ret_data, 32'h5555_AAAA);
    tick();

    // R9 issue during flush
    iss_valid = 1'b1; iss_addr = 32'h0000_7000; iss_kind = 3'b010; flush = 1'b1;
    #0.5;
    chk("R9 mreq_valid", 32'(mreq_valid), 32'd0);
    tick();
    iss_valid = 1'b0; flush = 1'b0;
    ep_m = (ep_m + 1) % 4;
    tail_m = 0;
    chk("R9 nothing queued", 32'(ret_valid), 32'd0);
    issue(3'b100, 32'h0000_7003, tn);
    respond(tn, 32'hC3000000);
    chk("R9 retire after flush", ret_data, 32'h0000_00C3);
    tick();
    chk("R9 drained", 32'(ret_valid), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule